// File: doc/BRIEF.md
# Fault and Soft-Start Sequencer

This block decides when the power-stage gate drivers of a switching converter controller may run, and produces the digital soft-start ramp that limits the control level during start-up. It takes two supply comparator flags, one for above turn-on and one for below turn-off, plus a non-latching enable, a latching shutdown request and a peak-current fault flag. It reports a ramp value, a driver enable, a ready flag and a latched-fault status.

Four conditions stop the drivers, checked in a fixed order every cycle: the shutdown latch first, then supply lockout, then the enable, then overcurrent. The latch, lockout and enable clear the ramp at once. An overcurrent instead starts a short, fast discharge followed by a fresh charge. If the overload is still present when charging restarts, the sequence repeats as a hiccup. Only the power-on reset clears the shutdown latch.

Top module: `ssq_top`

## Requirements
- R1: After reset, drivers stay off and the ramp stays 0 until `supAboveOn` has been seen high at a clock edge, even with `enableIn` high.
- R2: Supply hysteresis. Once `supAboveOn` has been seen, the supply counts as good while both flags are low. `supBelowOff` high at an edge turns drivers off and zeroes the ramp at that edge, and `supAboveOn` is then needed again.
- R3: `enableIn` low at an edge gives `rampOut`=0 and `drvEnable`=0 after that edge. When enable returns with no other blocking condition, the next edge sets `drvEnable`=1 with the ramp starting at 0.
- R4: While charging, `rampOut` rises by CHARGE_STEP at each edge and saturates at 2^RAMP_W-1. One edge after it reaches that top value, the block is running and the ramp holds.
- R5: `pkFault` high while drivers are on turns the drivers off at the next edge, with the ramp unchanged. The block then discharges for DISCH_CYCLES edges, each subtracting ceil((2^RAMP_W-1)/DISCH_CYCLES) and stopping at 0. At the last of those edges it re-enters charging from that value with drivers on. `pkFault` is ignored during the discharge.
- R6: Hiccup. If `pkFault` is still high on the first charging cycle after a discharge, another discharge starts at the next edge. This repeats for as long as the fault persists.
- R7: `latchShutIn` high at an edge sets `faultLatched` and forces `rampOut`=0 and `drvEnable`=0. This state holds whatever `enableIn`, the supply flags or `pkFault` do, and only `rstN` low clears it.
- R8: `ssReady` is 1 exactly when `rampOut` >= READY_LEVEL. READY_LEVEL defaults to 32, the code for the 400 mV point.
- R9: While `rstN` is low: `rampOut`=0, `drvEnable`=0, `ssReady`=0 and `faultLatched`=0.
- R10: `pkFault` has no effect while enable is low or the supply is locked out. Drivers stay off and the ramp stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| supAboveOn | input | 1 | Supply above turn-on threshold |
| supBelowOff | input | 1 | Supply below turn-off threshold |
| enableIn | input | 1 | Non-latching run enable, active high |
| latchShutIn | input | 1 | Latching shutdown request, active high |
| pkFault | input | 1 | Peak-current fault flag |
| rampOut | output | RAMP_W | Soft-start ramp value |
| drvEnable | output | 1 | Gate drivers allowed to switch |
| ssReady | output | 1 | Ramp at or above READY_LEVEL |
| faultLatched | output | 1 | Shutdown latch is set |

## Verification
The bound checker watches the following on every cycle:
- the shutdown latch stays set, and while it is set the drivers are off and the ramp is zero;
- the drivers turn off one edge after the turn-off flag, after enable falls, or after a peak fault while running;
- the ramp never falls while the drivers stay on.

Only the bench scenarios show the rest:
- the exact ramp values;
- the length of the discharge;
- the hysteresis memory between the two supply flags;
- the hiccup repeating under a persistent fault;
- the latch being cleared by reset and not by enable.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DISCH  = 2'd1,
    ST_CHARGE = 2'd2,
    ST_RUN    = 2'd3
  } seqState_t;

  typedef struct packed {
    logic clr;
    logic inc;
    logic dec;
  } rampCmd_t;

endpackage

// File: rtl/ssq_ctrl.sv
module ssq_ctrl
  import ssq_pkg::*;
#(
  parameter int DISCH_CYCLES = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     supAboveOn,
  input  logic     supBelowOff,
  input  logic     enableIn,
  input  logic     latchShutIn,
  input  logic     pkFault,
  input  logic     rampFull,
  output rampCmd_t cmd,
  output logic     drvEnable,
  output logic     faultLatched
);

  localparam int CNT_W = (DISCH_CYCLES > 1) ? $clog2(DISCH_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DISCH_CYCLES - 1);

  seqState_t        stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic             uvloOkQ, uvloNow;
  logic             latchQ, latchNow;

  // supply good memory: turn-off flag wins, turn-on flag sets, else hold
  always_comb begin
    if (supBelowOff)     uvloNow = 1'b0;
    else if (supAboveOn) uvloNow = 1'b1;
    else                 uvloNow = uvloOkQ;
  end

  assign latchNow = latchQ | latchShutIn;

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    cmd    = '0;
    if (latchNow || !uvloNow || !enableIn) begin
      // latch, lockout, enable in that order; all force a hard clear
      stateD  = ST_IDLE;
      cntD    = '0;
      cmd.clr = 1'b1;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          stateD = ST_CHARGE;
        end
        ST_DISCH: begin
          cmd.dec = 1'b1;
          if (cntQ == CNT_LAST) begin
            stateD = ST_CHARGE;
            cntD   = '0;
          end else begin
            cntD = cntQ + 1'b1;
          end
        end
        ST_CHARGE: begin
          if (pkFault) begin
            stateD = ST_DISCH;
            cntD   = '0;
          end else if (rampFull) begin
            stateD = ST_RUN;
          end else begin
            cmd.inc = 1'b1;
          end
        end
        ST_RUN: begin
          if (pkFault) begin
            stateD = ST_DISCH;
            cntD   = '0;
          end
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      cntQ    <= '0;
      uvloOkQ <= 1'b0;
      latchQ  <= 1'b0;
    end else begin
      stateQ  <= stateD;
      cntQ    <= cntD;
      uvloOkQ <= uvloNow;
      latchQ  <= latchNow;
    end
  end

  assign drvEnable    = (stateQ == ST_CHARGE) || (stateQ == ST_RUN);
  assign faultLatched = latchQ;

endmodule

// File: rtl/ssq_ramp.sv
module ssq_ramp
  import ssq_pkg::*;
#(
  parameter int RAMP_W       = 8,
  parameter int CHARGE_STEP  = 16,
  parameter int DISCH_CYCLES = 4,
  parameter int READY_LEVEL  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  rampCmd_t          cmd,
  output logic [RAMP_W-1:0] rampOut,
  output logic              rampFull,
  output logic              ssReady
);

  localparam int RAMP_MAX = (2 ** RAMP_W) - 1;
  localparam int DIS_STEP = (RAMP_MAX + DISCH_CYCLES - 1) / DISCH_CYCLES;
  localparam logic [RAMP_W:0] MAX_EXT = (RAMP_W+1)'(RAMP_MAX);
  localparam logic [RAMP_W:0] INC_EXT = (RAMP_W+1)'(CHARGE_STEP);
  localparam logic [RAMP_W:0] DEC_EXT = (RAMP_W+1)'(DIS_STEP);

  logic [RAMP_W-1:0] rampQ, rampD;
  logic [RAMP_W:0]   sumExt, diffExt;

  assign sumExt  = {1'b0, rampQ} + INC_EXT;
  assign diffExt = {1'b0, rampQ} - DEC_EXT;

  always_comb begin
    rampD = rampQ;
    if (cmd.clr) begin
      rampD = '0;
    end else if (cmd.inc) begin
      rampD = (sumExt > MAX_EXT) ? MAX_EXT[RAMP_W-1:0] : sumExt[RAMP_W-1:0];
    end else if (cmd.dec) begin
      rampD = ({1'b0, rampQ} < DEC_EXT) ? '0 : diffExt[RAMP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rampQ <= '0;
    else       rampQ <= rampD;
  end

  assign rampOut  = rampQ;
  assign rampFull = ({1'b0, rampQ} == MAX_EXT);

  generate
    if (READY_LEVEL <= 0) begin : g_readyAlways
      assign ssReady = rstN;
    end else begin : g_readyCmp
      assign ssReady = ({1'b0, rampQ} >= (RAMP_W+1)'(READY_LEVEL));
    end
  endgenerate

endmodule

// File: rtl/ssq_top.sv
module ssq_top
  import ssq_pkg::*;
#(
  parameter int RAMP_W       = 8,
  parameter int CHARGE_STEP  = 16,
  parameter int DISCH_CYCLES = 4,
  parameter int READY_LEVEL  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supAboveOn,
  input  logic              supBelowOff,
  input  logic              enableIn,
  input  logic              latchShutIn,
  input  logic              pkFault,
  output logic [RAMP_W-1:0] rampOut,
  output logic              drvEnable,
  output logic              ssReady,
  output logic              faultLatched
);

  rampCmd_t rampCmd;
  logic     rampFull;

  ssq_ctrl #(.DISCH_CYCLES(DISCH_CYCLES)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .supAboveOn   (supAboveOn),
    .supBelowOff  (supBelowOff),
    .enableIn     (enableIn),
    .latchShutIn  (latchShutIn),
    .pkFault      (pkFault),
    .rampFull     (rampFull),
    .cmd          (rampCmd),
    .drvEnable    (drvEnable),
    .faultLatched (faultLatched)
  );

  ssq_ramp #(
    .RAMP_W       (RAMP_W),
    .CHARGE_STEP  (CHARGE_STEP),
    .DISCH_CYCLES (DISCH_CYCLES),
    .READY_LEVEL  (READY_LEVEL)
  ) u_ramp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (rampCmd),
    .rampOut  (rampOut),
    .rampFull (rampFull),
    .ssReady  (ssReady)
  );

endmodule

// File: rtl/ssq_chk.sv
module ssq_chk #(
  parameter int RAMP_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              supBelowOff,
  input logic              enableIn,
  input logic              latchShutIn,
  input logic              pkFault,
  input logic [RAMP_W-1:0] rampOut,
  input logic              drvEnable,
  input logic              faultLatched
);

  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched |=> faultLatched);

  p_latch_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched |-> (!drvEnable && rampOut == '0));

  p_below_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    supBelowOff |=> !drvEnable);

  p_enable_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    !enableIn |=> (!drvEnable && rampOut == '0));

  p_fault_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pkFault && drvEnable) |=> !drvEnable);

  p_no_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    drvEnable |=> (!drvEnable || rampOut >= $past(rampOut)));

  p_latch_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    latchShutIn |=> faultLatched);

endmodule

bind ssq_top ssq_chk #(.RAMP_W(RAMP_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .supBelowOff  (supBelowOff),
  .enableIn     (enableIn),
  .latchShutIn  (latchShutIn),
  .pkFault      (pkFault),
  .rampOut      (rampOut),
  .drvEnable    (drvEnable),
  .faultLatched (faultLatched)
);

// File: tb/sim_ssq_top.sv
module sim_ssq_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       supAboveOn = 1'b0, supBelowOff = 1'b0, enableIn = 1'b0;
  logic       latchShutIn = 1'b0, pkFault = 1'b0;
  logic [7:0] rampOut;
  logic       drvEnable, ssReady, faultLatched;
  int         nChecks = 0, nFails = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  ssq_top #(.RAMP_W(8), .CHARGE_STEP(16), .DISCH_CYCLES(4), .READY_LEVEL(32)) u0 (
    .clk(clk), .rstN(rstN), .supAboveOn(supAboveOn), .supBelowOff(supBelowOff),
    .enableIn(enableIn), .latchShutIn(latchShutIn), .pkFault(pkFault),
    .rampOut(rampOut), .drvEnable(drvEnable), .ssReady(ssReady),
    .faultLatched(faultLatched)
  );

  // entry: {above, below, en, lsd, pk}, hold cycles, ramp, {drv, ready, latched}
  localparam int NV = 23;
  localparam logic [23:0] VEC [NV] = '{
    {5'b00100, 8'd3,  8'd0,   3'b000},  // R1 lockout
    {5'b10100, 8'd1,  8'd0,   3'b100},  // R1 start
    {5'b00100, 8'd2,  8'd32,  3'b110},  // R2 hold, R8 ready
    {5'b00100, 8'd13, 8'd240, 3'b110},  // R4
    {5'b00100, 8'd1,  8'd255, 3'b110},  // R4 saturate
    {5'b00100, 8'd1,  8'd255, 3'b110},  // R4 run
    {5'b00101, 8'd1,  8'd255, 3'b010},  // R5 off
    {5'b00101, 8'd1,  8'd191, 3'b010},  // R5 discharge
    {5'b00101, 8'd3,  8'd0,   3'b100},  // R5 recharge
    {5'b00101, 8'd1,  8'd0,   3'b000},  // R6 hiccup
    {5'b00100, 8'd4,  8'd0,   3'b100},  // R6 cleared
    {5'b00100, 8'd5,  8'd80,  3'b110},  // R4
    {5'b00000, 8'd1,  8'd0,   3'b000},  // R3 off
    {5'b00000, 8'd2,  8'd0,   3'b000},  // R3
    {5'b00100, 8'd1,  8'd0,   3'b100},  // R3 restart
    {5'b00100, 8'd3,  8'd48,  3'b110},  // R3
    {5'b01100, 8'd1,  8'd0,   3'b000},  // R2 turn-off
    {5'b00100, 8'd2,  8'd0,   3'b000},  // R2 memory
    {5'b10100, 8'd2,  8'd16,  3'b100},  // R2 back on
    {5'b10110, 8'd1,  8'd0,   3'b001},  // R7 set
    {5'b10000, 8'd2,  8'd0,   3'b001},  // R7
    {5'b10100, 8'd3,  8'd0,   3'b001},  // R7 enable cannot clear
    {5'b10101, 8'd1,  8'd0,   3'b001}   // R7 over fault
  };

  function automatic string vecTag(int i);
    case (i)
      0, 1:               return "R1";
      2, 16, 17, 18:      return "R2";
      12, 13, 14, 15:     return "R3";
      3, 4, 5, 11:        return "R4";
      6, 7, 8:            return "R5";
      9, 10:              return "R6";
      default:            return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic checkAll(input string tag, input int r, input int d, input int y, input int l);
    check(tag, "rampOut", int'(rampOut), r);
    check(tag, "drvEnable", int'(drvEnable), d);
    check(tag, "ssReady", int'(ssReady), y);
    check(tag, "faultLatched", int'(faultLatched), l);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    // R9 reset state
    step(3);
    checkAll("R9", 0, 0, 0, 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {supAboveOn, supBelowOff, enableIn, latchShutIn, pkFault} = VEC[i][23:19];
      step(int'(VEC[i][18:11]));
      checkAll(vecTag(i), int'(VEC[i][10:3]), int'(VEC[i][2]), int'(VEC[i][1]), int'(VEC[i][0]));
    end

    // R9 / R7: reset clears the latch
    {supAboveOn, supBelowOff, enableIn, latchShutIn, pkFault} = 5'b10100;
    rstN = 1'b0;
    step(2);
    checkAll("R9", 0, 0, 0, 0);
    rstN = 1'b1;
    step(1);
    checkAll("R7", 0, 1, 0, 0);
    step(2);
    checkAll("R8", 32, 1, 1, 0);

    // R5: single-cycle fault, discharge lasts four edges
    pkFault = 1'b1;
    step(1);
    checkAll("R5", 32, 0, 1, 0);
    pkFault = 1'b0;
    step(3);
    checkAll("R5", 0, 0, 0, 0);
    step(1);
    checkAll("R5", 0, 1, 0, 0);
    step(2);
    checkAll("R4", 32, 1, 1, 0);

    // R10: fault with enable low has no effect
    enableIn = 1'b0;
    pkFault = 1'b1;
    step(3);
    checkAll("R10", 0, 0, 0, 0);
    enableIn = 1'b1;
    pkFault = 1'b0;
    step(1);
    checkAll("R10", 0, 1, 0, 0);

    // R10: fault during lockout has no effect
    supBelowOff = 1'b1;
    pkFault = 1'b1;
    step(2);
    checkAll("R10", 0, 0, 0, 0);

    finish();
  end

endmodule